// File: doc/BRIEF.md
# Line-Buffered Vertical Convolution Stage

This block applies a K-tap filter down the columns of an image that arrives one sample at a time, row after row, on a valid/ready stream. The stream normally comes from a horizontal filter, so each row is already shortened; the row length and the number of rows per frame are set on configuration inputs. The block does not hold the frame. It keeps only the K-1 previous rows in line memories, each indexed by column.

For every accepted sample, the values stored at the same column in all line memories are read together. They are combined with the new sample in a signed multiply-accumulate. Then each stored column moves up by one line: the oldest value is dropped and the new sample goes into the newest line. The new sample feeds the sum directly, so K-1 lines are enough rather than K. No result exists until K-1 rows of the frame have been seen, so the first K-1 rows of every frame produce no output. After that there is exactly one result per input sample, at a rate of one per clock. A full output register that is not being taken stops intake and freezes all state.

Top module: `vconv_stage`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0 and in_ready is 1.
- R2: The result for the sample at row r, column c equals the sum over i = 0..K-1 of coef[i] * x[r-K+1+i][c]. Row r is counted from the start of the frame, and x holds the samples accepted in the current frame.
- R3: Samples in rows 0 to K-2 of a frame produce no output. Every sample accepted in a later row produces exactly one output, in the order of acceptance.
- R4: After cfg_rows rows of cfg_cols samples each, the row count returns to 0. The next frame's first K-1 rows then give no output and never mix with the previous frame's data.
- R5: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and out_data keep their values in the next cycle.
- R6: in_ready is 1 whenever out_valid is 0 or out_ready is 1, so one sample can be taken every clock. out_valid drops to 0 after a cycle in which the output was taken and no input was accepted.
- R7: Coefficient i occupies coef_flat[i*COEF_W +: COEF_W]. Index 0 weights the oldest row and index K-1 weights the incoming row.
- R8: Samples and coefficients are signed two's complement. out_data is the full-precision signed sum, DATA_W+COEF_W+clog2(K) bits wide, and does not overflow for extreme operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | clog2(MAX_COLS+1) | Samples per row (1..MAX_COLS) |
| cfg_rows | input | clog2(MAX_ROWS+1) | Rows per frame (1..MAX_ROWS) |
| coef_flat | input | TAPS*COEF_W | Packed signed vertical coefficients |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed filtered result |

## Verification
The checker keeps its own row and column count, built from accepted handshakes and the configuration inputs. It therefore assumes that cfg_cols and cfg_rows stay constant while a frame is in flight and lie within their legal ranges. It also assumes that a frame always ends with all of its rows. The stimulus changes configuration only after the previous frame has been fully sent and drained, and uses widths up to the full line-memory depth. Valid and ready are random, mixed with directed frames that use extreme operands and single-tap coefficient patterns.

// File: rtl/vconv_pkg.sv
package vconv_pkg;

   // width of a full-precision sum of n products of dw x cw signed operands
   function automatic int sum_width(input int dw, input int cw, input int n);
      return dw + cw + $clog2(n);
   endfunction

   function automatic int cnt_width(input int max_count);
      return (max_count < 2) ? 1 : $clog2(max_count + 1);
   endfunction

endpackage

// File: rtl/vconv_line_store.sv
module vconv_line_store #(
   parameter int DATA_W = 8,
   parameter int LINES  = 2,
   parameter int DEPTH  = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        idx,
   input  logic [DATA_W-1:0]       din,
   output logic [LINES*DATA_W-1:0] taps_flat
);

   // line 0 holds the oldest row, line LINES-1 the most recent one
   for (genvar j = 0; j < LINES; j++) begin : g_line
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DATA_W-1:0] wval;

      assign taps_flat[j*DATA_W +: DATA_W] = mem[idx];

      if (j == LINES - 1) begin : g_newest
         assign wval = din;
      end else begin : g_shift
         assign wval = g_line[j+1].mem[idx];
      end

      always_ff @(posedge clk) begin
         if (wr_en) begin
            mem[idx] <= wval;
         end
      end
   end

endmodule

// File: rtl/vconv_position.sv
module vconv_position #(
   parameter int TAPS  = 3,
   parameter int COL_W = 7,
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [COL_W-1:0] cfg_cols,
   input  logic [ROW_W-1:0] cfg_rows,
   output logic [COL_W-1:0] col,
   output logic             emit
);

   localparam int FILL = TAPS - 1;

   logic [ROW_W-1:0] row;
   logic             last_col;
   logic             last_row;

   assign last_col = (col == cfg_cols - COL_W'(1));
   assign last_row = (row == cfg_rows - ROW_W'(1));
   assign emit     = (32'(row) >= FILL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (step) begin
         if (last_col) begin
            col <= '0;
            row <= last_row ? '0 : row + ROW_W'(1);
         end else begin
            col <= col + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/vconv_mac.sv
module vconv_mac #(
   parameter int DATA_W = 8,
   parameter int COEF_W = 8,
   parameter int TAPS   = 3,
   localparam int PROD_W = DATA_W + COEF_W,
   localparam int ACC_W  = vconv_pkg::sum_width(DATA_W, COEF_W, TAPS)
) (
   input  logic [TAPS*DATA_W-1:0] taps_flat,
   input  logic [TAPS*COEF_W-1:0] coef_flat,
   output logic [ACC_W-1:0]       sum
);

   logic signed [ACC_W-1:0] prod_ext [TAPS];

   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      logic signed [DATA_W-1:0] a;
      logic signed [COEF_W-1:0] b;
      logic signed [PROD_W-1:0] p;
      assign a = taps_flat[g*DATA_W +: DATA_W];
      assign b = coef_flat[g*COEF_W +: COEF_W];
      assign p = a * b;
      assign prod_ext[g] = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
   end

   always_comb begin
      logic signed [ACC_W-1:0] acc;
      acc = '0;
      for (int k = 0; k < TAPS; k++) begin
         acc = acc + prod_ext[k];
      end
      sum = acc;
   end

endmodule

// File: rtl/vconv_stage.sv
module vconv_stage #(
   parameter int DATA_W   = 8,
   parameter int COEF_W   = 8,
   parameter int TAPS     = 3,
   parameter int MAX_COLS = 64,
   parameter int MAX_ROWS = 1080,
   localparam int COL_W = vconv_pkg::cnt_width(MAX_COLS),
   localparam int ROW_W = vconv_pkg::cnt_width(MAX_ROWS),
   localparam int ACC_W = vconv_pkg::sum_width(DATA_W, COEF_W, TAPS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [COL_W-1:0]       cfg_cols,
   input  logic [ROW_W-1:0]       cfg_rows,
   input  logic [TAPS*COEF_W-1:0] coef_flat,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [DATA_W-1:0]      in_data,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [ACC_W-1:0]       out_data
);

   localparam int LINES = TAPS - 1;
   localparam int IDX_W = $clog2(MAX_COLS);

   if (TAPS < 2) begin : g_bad_taps
      $error("vconv_stage: TAPS must be at least 2");
   end
   if (MAX_COLS < 2) begin : g_bad_cols
      $error("vconv_stage: MAX_COLS must be at least 2");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("vconv_stage: operand widths must be at least 2");
   end

   logic                    take;
   logic                    emit;
   logic [COL_W-1:0]        col;
   logic [LINES*DATA_W-1:0] line_taps;
   logic [TAPS*DATA_W-1:0]  all_taps;
   logic [ACC_W-1:0]        sum;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;
   assign all_taps = {in_data, line_taps};

   vconv_position #(
      .TAPS (TAPS),
      .COL_W(COL_W),
      .ROW_W(ROW_W)
   ) pos_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (take),
      .cfg_cols(cfg_cols),
      .cfg_rows(cfg_rows),
      .col     (col),
      .emit    (emit)
   );

   vconv_line_store #(
      .DATA_W(DATA_W),
      .LINES (LINES),
      .DEPTH (MAX_COLS)
   ) lines_i (
      .clk      (clk),
      .wr_en    (take),
      .idx      (col[IDX_W-1:0]),
      .din      (in_data),
      .taps_flat(line_taps)
   );

   vconv_mac #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .TAPS  (TAPS)
   ) mac_i (
      .taps_flat(all_taps),
      .coef_flat(coef_flat),
      .sum      (sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= take && emit;
         if (take && emit) begin
            out_data <= sum;
         end
      end
   end

endmodule

// File: rtl/vconv_stage_chk.sv
module vconv_stage_chk #(
   parameter int TAPS  = 3,
   parameter int COL_W = 7,
   parameter int ROW_W = 11,
   parameter int ACC_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic [COL_W-1:0] cfg_cols,
   input logic [ROW_W-1:0] cfg_rows,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [ACC_W-1:0] out_data
);

   logic             acc;
   logic [COL_W-1:0] c_col;
   logic [ROW_W-1:0] c_row;
   logic             early;

   assign acc   = in_valid && in_ready;
   assign early = (32'(c_row) < TAPS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_col <= '0;
         c_row <= '0;
      end else if (acc) begin
         if (c_col == cfg_cols - COL_W'(1)) begin
            c_col <= '0;
            c_row <= (c_row == cfg_rows - ROW_W'(1)) ? '0 : c_row + ROW_W'(1);
         end else begin
            c_col <= c_col + COL_W'(1);
         end
      end
   end

   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
   AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R5
   AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready); // R6
   AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && early) |=> !out_valid); // R3
   AST_EMIT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !early) |=> out_valid); // R3
   AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && (!out_valid || out_ready)) |=> !out_valid); // R6

endmodule

bind vconv_stage vconv_stage_chk #(
   .TAPS (TAPS),
   .COL_W(COL_W),
   .ROW_W(ROW_W),
   .ACC_W(ACC_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_cols (cfg_cols),
   .cfg_rows (cfg_rows),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data)
);

// File: tb/vconv_stage_tb.sv
module vconv_stage_tb_top;

   localparam int DW = 8;
   localparam int CW = 8;
   localparam int K  = 3;
   localparam int MC = 16;
   localparam int MR = 8;
   localparam int COL_W = vconv_pkg::cnt_width(MC);
   localparam int ROW_W = vconv_pkg::cnt_width(MR);
   localparam int AW    = vconv_pkg::sum_width(DW, CW, K);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [COL_W-1:0]     cfg_cols = '0;
   logic [ROW_W-1:0]     cfg_rows = '0;
   logic [K*CW-1:0]      coef_flat = '0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [DW-1:0]        in_data = '0;
   logic                 out_valid;
   logic                 out_ready = 1'b0;
   logic [AW-1:0]        out_data;

   int total = 0;
   int bad   = 0;

   int img [MR][MC];
   int coef [K];
   longint expq [$];

   always #10 clk = ~clk;

   vconv_stage #(
      .DATA_W(DW), .COEF_W(CW), .TAPS(K), .MAX_COLS(MC), .MAX_ROWS(MR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
      .coef_flat(coef_flat), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R7: coefficient i sits at bits [i*CW +: CW]
   task automatic set_coefs(input int c0, input int c1, input int c2);
      coef[0] = c0; coef[1] = c1; coef[2] = c2;
      for (int i = 0; i < K; i++) coef_flat[i*CW +: CW] = CW'(coef[i]);
   endtask

   // R2: expected sum from bench-side frame copy
   function automatic longint expect_at(input int r, input int c);
      longint s = 0;
      for (int i = 0; i < K; i++) s += longint'(coef[i]) * img[r-K+1+i][c];
      return s;
   endfunction

   // mode 0 random data, 1 all -128, 2 data = row*16+col
   task automatic run_frame(input int cols, input int rows, input int vpct,
                            input int rpct, input int mode, input string tag);
      int n = cols * rows;
      int idx = 0;
      int r = 0, c = 0;
      bit stall_prev = 0;
      longint prev_data = 0;
      cfg_cols = COL_W'(cols);
      cfg_rows = ROW_W'(rows);
      while (idx < n || expq.size() != 0 || out_valid) begin
         @(negedge clk);
         in_valid  = (idx < n) && (($urandom % 100) < vpct);
         out_ready = (($urandom % 100) < rpct);
         case (mode)
            1: in_data = DW'(-128);
            2: in_data = DW'(r * 16 + c);
            default: in_data = DW'($urandom);
         endcase
         #5;
         if (stall_prev) begin
            check(out_valid && ($signed(out_data) == prev_data), "R5 hold",
                  $signed(out_data), prev_data);
         end
         if (out_valid && !out_ready) begin
            check(!in_ready, "R5 ready", in_ready, 0);
            stall_prev = 1;
            prev_data  = $signed(out_data);
         end else begin
            stall_prev = 0;
         end
         if (!out_valid) check(in_ready, "R6 ready", in_ready, 1);
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(0, "R3 extra output", $signed(out_data), 0);
            end else begin
               longint e = expq.pop_front();
               check($signed(out_data) == e, tag, $signed(out_data), e);
            end
         end
         if (in_valid && in_ready) begin
            img[r][c] = $signed(in_data);
            if (r >= K - 1) expq.push_back(expect_at(r, c));
            idx++;
            if (c == cols - 1) begin
               c = 0;
               r = r + 1;
            end else begin
               c++;
            end
         end
      end
      in_valid  = 0;
      out_ready = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      check(out_valid == 0, "R1 out_valid", out_valid, 0);
      check(in_ready == 1, "R1 in_ready", in_ready, 1);
      check(out_data == 0, "R1 out_data", out_data, 0);

      set_coefs(3, -5, 7);
      run_frame(5, 4, 80, 70, 0, "R2 random");
      // R4: back-to-back frames, second must not see the first
      run_frame(5, 4, 100, 100, 0, "R4 frame wrap");
      run_frame(MC, 6, 60, 50, 0, "R2 full width");
      run_frame(1, 5, 90, 40, 0, "R2 single column");
      // R7: only index 0 set, result is the oldest row
      set_coefs(1, 0, 0);
      run_frame(4, 5, 100, 100, 2, "R7 oldest tap");
      set_coefs(0, 0, 1);
      run_frame(4, 4, 70, 90, 2, "R7 newest tap");
      // R8: extremes
      set_coefs(-128, -128, -128);
      run_frame(6, 4, 100, 60, 1, "R8 extreme");
      set_coefs(127, -128, 127);
      for (int f = 0; f < 4; f++) run_frame(3 + f * 3, 3 + f, 50, 50, 0, "R2 mixed");
      check(expq.size() == 0, "R3 pending", expq.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule